// File: doc/BRIEF.md
# Auto-Ranging Gain Step Controller

This block sits between a 12-bit converter and a programmable amplifier that feeds it. For each sample it accepts, it checks the code against two limits. A code over the upper limit lowers the amplifier gain by one power-of-two level. A code under the lower limit raises the gain by one level. Any other code leaves the gain as it is. The gain is held as an index: index i means a gain of 2^(i+1), so index 0 is gain 2 and index 4 is gain 32. The index always stays between a configured floor, a configured ceiling and the hard top of 4.

Each accepted sample is also stored in a result register. The register is tagged with the gain index that was in effect when the sample was taken, so a consumer can scale the code correctly. A ready flag marks new data. The consumer clears the flag with an acknowledge. A sticky overrun flag records that a result was overwritten before it was acknowledged.

After a gain step the amplifier needs time to settle. For that reason a programmable number of the following samples is left out of range decisions. Those samples are still latched as results. A configuration check warns when the two limits are set so close that one gain step up would at once be followed by a step down.

The decision logic is a two-state machine:
- In state `ST_RUN`, range decisions are live. The transition `step_taken` goes to `ST_SETTLE` when a step is taken and the settle count is not zero.
- In state `ST_SETTLE`, each accepted sample lowers the blanking counter. The transition `settle_done` returns to `ST_RUN` when the last blanked sample has been consumed.

Suggested settings are: upper limit 3890, lower limit 1638, floor index 0, ceiling index 2, settle count 2.

Top module: `gain_ranger`

## Requirements
- R1: After reset the gain index is 0, and `res_ready`, `res_overrun`, `step_up` and `step_down` are all 0.
- R2: A sample whose code is strictly greater than `hi_lim` lowers the gain index by exactly 1 when the index is above `gain_floor`. The new index and a one-cycle `step_down` pulse appear one clock edge after the edge that accepted the sample.
- R3: A sample whose code is strictly less than `lo_lim` raises the gain index by exactly 1 when the index is below both `gain_ceil` and 4. The new index and a one-cycle `step_up` pulse follow the same timing as in R2.
- R4: A code equal to either limit, or lying between them, leaves the gain index unchanged and produces no pulse.
- R5: No step is taken below `gain_floor`, above `gain_ceil`, or above index 4, even when `gain_ceil` is set higher than 4.
- R6: When a code is both above `hi_lim` and below `lo_lim`, which can only happen with crossed limits, the downward step wins.
- R7: After a step, the next `settle_n` accepted samples cause no step. When `settle_n` is 0, no sample is blanked.
- R8: Every accepted sample is latched into `res_code` at the accepting edge. At the same edge `res_gain` takes the index that was in effect just before that edge, and `res_ready` is set.
- R9: `res_ack` clears `res_ready` and `res_overrun`. When `res_ack` and a valid sample arrive in the same cycle, the new sample is latched, `res_ready` stays 1 and `res_overrun` becomes 0.
- R10: A valid sample arriving while `res_ready` is 1 and `res_ack` is 0 sets `res_overrun`, which stays set until acknowledged.
- R11: `cfg_err` is 1 exactly when 2 × `lo_lim` is greater than or equal to `hi_lim`.
- R12: At most one step is taken per sample, and `step_up` and `step_down` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_code | input | 12 | Unsigned converter code |
| hi_lim | input | 12 | Upper limit; a code above it steps the gain down |
| lo_lim | input | 12 | Lower limit; a code below it steps the gain up |
| gain_floor | input | 3 | Lowest allowed gain index |
| gain_ceil | input | 3 | Highest allowed gain index (also capped at 4) |
| settle_n | input | 4 | Number of samples blanked after each step |
| res_ack | input | 1 | Consumer acknowledge; clears ready and overrun |
| gain_idx | output | 3 | Current gain index (gain = 2^(index+1)) |
| res_code | output | 12 | Most recent sample code |
| res_gain | output | 3 | Gain index in effect for `res_code` |
| res_ready | output | 1 | New result present |
| res_overrun | output | 1 | Sticky flag: a result was overwritten before it was acknowledged |
| step_up | output | 1 | One-cycle pulse when the gain rises |
| step_down | output | 1 | One-cycle pulse when the gain falls |
| cfg_err | output | 1 | The limits risk oscillation |

## Verification
A wrong index, or a wrong blanking counter, shows up at `gain_idx` and on the step pulses at the edge after the first sample that should have been judged differently. The next result's `res_gain` tag then carries the same error. The scoreboard predicts the index, the tag and the pulses for each sample, so a divergence is caught within one sample. A stuck blanking state is caught on the first sample after the settle window, when the expected step fails to happen. The flag handling is checked at the ports in three cases: back-to-back samples without an acknowledge, an acknowledge that coincides with a sample, and an acknowledge on its own.

// File: rtl/gr_pkg.sv
package gr_pkg;
    localparam int CODE_W   = 12;
    localparam int IDX_W    = 3;
    localparam int MAX_IDX  = 4;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SETTLE = 1'b1
    } gr_state_e;
endpackage

// File: rtl/gr_window.sv
module gr_window
    import gr_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic [W-1:0] code,
    input  logic [W-1:0] hi_lim,
    input  logic [W-1:0] lo_lim,
    output logic         above,
    output logic         below,
    output logic         cfg_err
);
    localparam int WX = W + 1;
    logic [WX-1:0] lo_dbl;

    always_comb begin
        above   = code > hi_lim;
        below   = code < lo_lim;
        lo_dbl  = {lo_lim, 1'b0};
        cfg_err = lo_dbl >= {1'b0, hi_lim};
    end
endmodule

// File: rtl/gr_result.sv
module gr_result
    import gr_pkg::*;
#(
    parameter int W  = CODE_W,
    parameter int GW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic [W-1:0]  code,
    input  logic [GW-1:0] gain_now,
    input  logic          ack,
    output logic [W-1:0]  res_code,
    output logic [GW-1:0] res_gain,
    output logic          ready,
    output logic          overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_code <= '0;
            res_gain <= '0;
            ready    <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (vld) begin
                res_code <= code;
                res_gain <= gain_now;
            end
            ready   <= vld | (ready & ~ack);
            overrun <= ~ack & (overrun | (vld & ready));
        end
    end

    // R10: an unacknowledged overwrite is flagged
    a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && ready && !ack) |=> overrun);
    // R9: a lone acknowledge clears both flags
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !vld) |=> (!ready && !overrun));
    // R8: every accepted sample leaves data ready
    a_r8_ready_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> ready);
endmodule

// File: rtl/gr_step_fsm.sv
module gr_step_fsm
    import gr_pkg::*;
#(
    parameter int GW = IDX_W,
    parameter int SW = 4,
    parameter int TOP = MAX_IDX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval_vld,
    input  logic          above,
    input  logic          below,
    input  logic [GW-1:0] floor_idx,
    input  logic [GW-1:0] ceil_idx,
    input  logic [SW-1:0] settle_n,
    output logic [GW-1:0] gain,
    output logic          up_p,
    output logic          dn_p
);
    localparam logic [GW-1:0] TOP_IDX = GW'(TOP);

    gr_state_e     state, state_n;
    logic [SW-1:0] cnt, cnt_n;
    logic [GW-1:0] gain_n;
    logic          up_n, dn_n, stepped;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        gain_n  = gain;
        up_n    = 1'b0;
        dn_n    = 1'b0;
        stepped = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (eval_vld) begin
                    if (above) begin
                        if (gain > floor_idx) begin
                            gain_n  = gain - 1'b1;
                            dn_n    = 1'b1;
                            stepped = 1'b1;
                        end
                    end else if (below) begin
                        if (gain < ceil_idx && gain < TOP_IDX) begin
                            gain_n  = gain + 1'b1;
                            up_n    = 1'b1;
                            stepped = 1'b1;
                        end
                    end
                    if (stepped && settle_n != '0) begin
                        state_n = ST_SETTLE;
                        cnt_n   = settle_n;
                    end
                end
            end
            ST_SETTLE: begin
                if (eval_vld) begin
                    cnt_n = cnt - 1'b1;
                    if (cnt == SW'(1)) state_n = ST_RUN;
                end
            end
            default: state_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain <= '0;
            up_p <= 1'b0;
            dn_p <= 1'b0;
        end else begin
            gain <= gain_n;
            up_p <= up_n;
            dn_p <= dn_n;
        end
    end

    // R2: a down pulse goes with a single-level drop
    a_r2_down_one: assert property (@(posedge clk) disable iff (!rst_n)
        dn_p |-> (gain == $past(gain) - 1'b1));
    // R3: an up pulse goes with a single-level rise
    a_r3_up_one: assert property (@(posedge clk) disable iff (!rst_n)
        up_p |-> (gain == $past(gain) + 1'b1));
    // R12: never both directions at once
    a_r12_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_p && dn_p));
    // R5: index never passes the hard top
    a_r5_top: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= TOP_IDX);
    // R7: steps only come from the live state
    a_r7_no_step_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        (up_p || dn_p) |-> ($past(state) == ST_RUN));
    // R7: the blanking state always has samples left to skip
    a_r7_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> (cnt != '0));
    // R4: without a pulse the index holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_p && !dn_p) |-> $stable(gain));
endmodule

// File: rtl/gain_ranger.sv
module gain_ranger
    import gr_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int GW = IDX_W,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [CW-1:0] smp_code,
    input  logic [CW-1:0] hi_lim,
    input  logic [CW-1:0] lo_lim,
    input  logic [GW-1:0] gain_floor,
    input  logic [GW-1:0] gain_ceil,
    input  logic [SW-1:0] settle_n,
    input  logic          res_ack,
    output logic [GW-1:0] gain_idx,
    output logic [CW-1:0] res_code,
    output logic [GW-1:0] res_gain,
    output logic          res_ready,
    output logic          res_overrun,
    output logic          step_up,
    output logic          step_down,
    output logic          cfg_err
);
    logic          s_vld;
    logic [CW-1:0] s_code;
    logic          above, below;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_vld  <= 1'b0;
            s_code <= '0;
        end else begin
            s_vld <= smp_valid;
            if (smp_valid) s_code <= smp_code;
        end
    end

    gr_window #(.W(CW)) u_win (
        .code    (s_code),
        .hi_lim  (hi_lim),
        .lo_lim  (lo_lim),
        .above   (above),
        .below   (below),
        .cfg_err (cfg_err)
    );

    gr_step_fsm #(.GW(GW), .SW(SW), .TOP(MAX_IDX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_vld  (s_vld),
        .above     (above),
        .below     (below),
        .floor_idx (gain_floor),
        .ceil_idx  (gain_ceil),
        .settle_n  (settle_n),
        .gain      (gain_idx),
        .up_p      (step_up),
        .dn_p      (step_down)
    );

    gr_result #(.W(CW), .GW(GW)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (smp_valid),
        .code     (smp_code),
        .gain_now (gain_idx),
        .ack      (res_ack),
        .res_code (res_code),
        .res_gain (res_gain),
        .ready    (res_ready),
        .overrun  (res_overrun)
    );

    // R8: the tag is the index that held just before the accepting edge
    a_r8_tag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(smp_valid) |-> (res_gain == $past(gain_idx)));
endmodule

// File: tb/sim_gain_ranger.sv
module sim_gain_ranger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_code = '0;
    logic [11:0] hi_lim = 12'd3890;
    logic [11:0] lo_lim = 12'd1638;
    logic [2:0]  gain_floor = 3'd0;
    logic [2:0]  gain_ceil = 3'd2;
    logic [3:0]  settle_n = 4'd2;
    logic        res_ack = 1'b0;
    logic [2:0]  gain_idx, res_gain;
    logic [11:0] res_code;
    logic        res_ready, res_overrun, step_up, step_down, cfg_err;

    always #10 clk = ~clk;

    gain_ranger u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .hi_lim(hi_lim), .lo_lim(lo_lim), .gain_floor(gain_floor),
        .gain_ceil(gain_ceil), .settle_n(settle_n), .res_ack(res_ack),
        .gain_idx(gain_idx), .res_code(res_code), .res_gain(res_gain),
        .res_ready(res_ready), .res_overrun(res_overrun), .step_up(step_up),
        .step_down(step_down), .cfg_err(cfg_err)
    );

    typedef struct {
        int code;
        int tag;
        int gain;
        int up;
        int dn;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    int   m_gain = 0;
    int   m_blank = 0;
    bit   mon_en = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: predicts from the requirements, pushes, then drives one sample
    task automatic send(input int code);
        exp_t e;
        int   ceil_eff;
        e.code = code;
        e.tag  = m_gain;
        e.up   = 0;
        e.dn   = 0;
        ceil_eff = (gain_ceil > 4) ? 4 : int'(gain_ceil);
        if (m_blank > 0) begin
            m_blank--;                                     // R7
        end else if (code > hi_lim) begin                  // R2, R6
            if (m_gain > gain_floor) begin
                m_gain--; e.dn = 1; m_blank = settle_n;
            end
        end else if (code < lo_lim) begin                  // R3, R5
            if (m_gain < ceil_eff) begin
                m_gain++; e.up = 1; m_blank = settle_n;
            end
        end
        e.gain = m_gain;
        q.push_back(e);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_code  = code[11:0];
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops one expected item per result
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (mon_en && res_ready) begin
                if (q.size() == 0) begin
                    chk("R8 unexpected result", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk("R8 res_code", int'(res_code), e.code);
                    chk("R8 res_gain tag", int'(res_gain), e.tag);
                    res_ack = 1'b1;
                    @(negedge clk);
                    res_ack = 1'b0;
                    chk("R2/R3/R4/R5/R7 gain_idx", int'(gain_idx), e.gain);
                    chk("R3 step_up", int'(step_up), e.up);
                    chk("R2 step_down", int'(step_down), e.dn);
                    chk("R12 single direction", int'(step_up & step_down), 0);
                    chk("R9 ready cleared by ack", int'(res_ready), 0);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 gain_idx", int'(gain_idx), 0);
        chk("R1 res_ready", int'(res_ready), 0);
        chk("R1 res_overrun", int'(res_overrun), 0);
        chk("R1 pulses", int'(step_up | step_down), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 cfg_err default limits", int'(cfg_err), 0);

        // R10 / R9: flag handling with the monitor off
        smp_valid = 1'b1; smp_code = 12'd2000;
        @(negedge clk);
        smp_code = 12'd2100;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R10 overrun set", int'(res_overrun), 1);
        chk("R10 last code kept", int'(res_code), 2100);
        @(negedge clk);
        chk("R10 overrun sticky", int'(res_overrun), 1);
        res_ack = 1'b1; smp_valid = 1'b1; smp_code = 12'd2200;
        @(negedge clk);
        res_ack = 1'b0; smp_valid = 1'b0;
        chk("R9 ack with sample ready", int'(res_ready), 1);
        chk("R9 ack with sample overrun", int'(res_overrun), 0);
        chk("R9 ack with sample code", int'(res_code), 2200);
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        chk("R9 ack clears ready", int'(res_ready), 0);
        chk("R4 in-window gain", int'(gain_idx), 0);
        mon_en = 1'b1;

        // R3 / R7 / R5 with ceiling 2
        for (int i = 0; i < 7; i++) send(500);
        // R2 / R7 / R4 downward and floor clamp
        send(4000);
        for (int i = 0; i < 3; i++) send(2500);
        for (int i = 0; i < 4; i++) send(4000);
        // R4 boundaries
        send(3890);
        send(1638);
        send(1637);
        send(2000); send(2000);
        send(3891);
        send(2000); send(2000);
        // R5 hard top with ceiling above 4, no blanking
        gain_ceil = 3'd7; settle_n = 4'd0;
        for (int i = 0; i < 6; i++) send(100);
        // R5 floor 2
        gain_floor = 3'd2;
        for (int i = 0; i < 4; i++) send(4095);
        // R6 crossed limits: down wins
        hi_lim = 12'd2000; lo_lim = 12'd3000; gain_floor = 3'd0;
        @(negedge clk);
        chk("R11 cfg_err crossed", int'(cfg_err), 1);
        send(2500);
        // R11 boundary: 2*lo == hi
        hi_lim = 12'd2000; lo_lim = 12'd1000;
        @(negedge clk);
        chk("R11 cfg_err equal", int'(cfg_err), 1);
        lo_lim = 12'd999;
        @(negedge clk);
        chk("R11 cfg_err just below", int'(cfg_err), 0);
        repeat (4) @(negedge clk);
        chk("R8 queue drained", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule